// File: doc/BRIEF.md
# Processor status and mode flag register

This block keeps the eight architectural status bits of a processor core, plus two hidden emulation select bits, and decides each cycle how they change. Arithmetic results update the carry, zero, overflow and negative flags through a per-flag write mask. Software writes the whole byte through a load port. Two swap commands are the only path that moves the emulation bits. One swap trades the narrow-emulation bit with carry. The other trades both emulation bits with carry and overflow.

While narrow emulation is active, the accumulator-width and index-width flags are held at one. A load cannot clear them. The block also forms the byte that the core writes to the stack. During an interrupt taken in narrow emulation, that byte carries the software-break indication in bit 4 and a one in bit 5. Every other push gets the plain status byte. The stack write itself happens elsewhere.

Top module: `psr_unit`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, status reads 8'h34 (bits 5, 4 and 2 set), emu_narrow reads 1 and emu_wide reads 0.
- R2: The status bit layout from bit 7 down to bit 0 is negative, overflow, accumulator width, index width, decimal, IRQ disable, zero, carry. With no swap and no load, each set bit of flag_we loads the matching bit of flag_val at the next clock edge, and each clear bit leaves its flag unchanged. The mask and value bit mapping is bit 3 negative, bit 2 overflow, bit 1 zero, bit 0 carry. Bits 5..2 are unchanged.
- R3: With load_we high and no swap, status takes load_data at the next edge, subject only to R7, and the emulation bits keep their values.
- R4: With swap_c_req high and swap_cv_req low, the carry flag and emu_narrow exchange values at the next edge.
- R5: With swap_cv_req high, emu_narrow exchanges with carry and emu_wide exchanges with overflow at the next edge. When both swap requests are high, this exchange is the one performed.
- R6: emu_narrow and emu_wide change only in a cycle where a swap request is high.
- R7: Whenever emu_narrow is 1, status bits 5 and 4 read 1. This includes the edge at which a swap sets emu_narrow, and any load that writes zeros there. After emu_narrow clears, these bits keep 1 until they are written.
- R8: Priority is swap over load over flag update. In a cycle with a swap request, load_we, flag_we and flag_val have no effect.
- R9: With irq_push high and emu_narrow at 1, push_byte equals status except that bit 4 equals sw_brk and bit 5 is 1. This holds in the same cycle.
- R10: Otherwise (irq_push low, or emu_narrow at 0), push_byte equals status in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_we | input | 4 | Per-flag write mask for arithmetic results (N,V,Z,C) |
| flag_val | input | 4 | Arithmetic flag values (N,V,Z,C) |
| load_we | input | 1 | Whole-byte load strobe |
| load_data | input | 8 | Byte written by a load |
| swap_c_req | input | 1 | Swap carry with the narrow-emulation bit |
| swap_cv_req | input | 1 | Swap carry/overflow with both emulation bits |
| irq_push | input | 1 | An interrupt entry is pushing the status byte |
| sw_brk | input | 1 | Interrupt was raised by a software break |
| status | output | 8 | Current status byte |
| emu_narrow | output | 1 | Narrow (8-bit) emulation mode bit |
| emu_wide | output | 1 | Wide (16-bit) emulation mode bit |
| push_byte | output | 8 | Byte to be written to the stack |

## Verification
A swap, a load and a flag update can all be requested in one cycle. The swap must win, and the other two must leave no trace. The bench raises these collisions both in directed steps and in random traffic. It raises both swaps together and pairs swaps with loads and masks that would otherwise change carry and overflow. A behavioural reference model applies the priority rule on its own, and the bench compares status and both mode bits after every edge. Width forcing on entry into emulation also lands in the same edge as a swap. It is judged by whether bits 5 and 4 read one at that edge.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int PSR_W    = 8;
    localparam int FLAG_W   = 4;
    localparam int B_C      = 0;
    localparam int B_Z      = 1;
    localparam int B_I      = 2;
    localparam int B_D      = 3;
    localparam int B_X      = 4;
    localparam int B_M      = 5;
    localparam int B_V      = 6;
    localparam int B_N      = 7;
    localparam int F_C      = 0;
    localparam int F_Z      = 1;
    localparam int F_V      = 2;
    localparam int F_N      = 3;
    localparam logic [PSR_W-1:0] PSR_RESET = (PSR_W'(1) << B_M) | (PSR_W'(1) << B_X)
                                           | (PSR_W'(1) << B_I);

    typedef struct packed {
        logic [PSR_W-1:0] p;
        logic             e16;
        logic             e8;
    } psr_t;
endpackage

// File: rtl/psr_xchg.sv
module psr_xchg
    import psr_pkg::*;
(
    input  psr_t st_i,
    input  logic swap_c,
    input  logic swap_cv,
    output psr_t st_o,
    output logic active
);
    always_comb begin
        st_o   = st_i;
        active = swap_c | swap_cv;
        if (swap_cv) begin
            st_o.e8     = st_i.p[B_C];
            st_o.p[B_C] = st_i.e8;
            st_o.e16    = st_i.p[B_V];
            st_o.p[B_V] = st_i.e16;
        end else if (swap_c) begin
            st_o.e8     = st_i.p[B_C];
            st_o.p[B_C] = st_i.e8;
        end
    end
endmodule

// File: rtl/psr_upd.sv
module psr_upd
    import psr_pkg::*;
(
    input  psr_t              st_i,
    input  logic [FLAG_W-1:0] flag_we,
    input  logic [FLAG_W-1:0] flag_val,
    input  logic              load_we,
    input  logic [PSR_W-1:0]  load_data,
    output psr_t              st_o
);
    logic [PSR_W-1:0] alu_p;

    for (genvar b = 0; b < PSR_W; b++) begin : g_bit
        localparam int SLOT = (b == B_C) ? F_C :
                              (b == B_Z) ? F_Z :
                              (b == B_V) ? F_V :
                              (b == B_N) ? F_N : -1;
        if (SLOT >= 0) begin : g_alu
            assign alu_p[b] = flag_we[SLOT] ? flag_val[SLOT] : st_i.p[b];
        end else begin : g_keep
            assign alu_p[b] = st_i.p[b];
        end
    end

    always_comb begin
        st_o   = st_i;
        st_o.p = load_we ? load_data : alu_p;
    end
endmodule

// File: rtl/psr_push.sv
module psr_push
    import psr_pkg::*;
(
    input  psr_t             st_i,
    input  logic             irq_push,
    input  logic             sw_brk,
    output logic [PSR_W-1:0] push_byte
);
    always_comb begin
        push_byte = st_i.p;
        if (irq_push && st_i.e8) begin
            push_byte[B_X] = sw_brk;
            push_byte[B_M] = 1'b1;
        end
    end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] flag_we,
    input  logic [FLAG_W-1:0] flag_val,
    input  logic              load_we,
    input  logic [PSR_W-1:0]  load_data,
    input  logic              swap_c_req,
    input  logic              swap_cv_req,
    input  logic              irq_push,
    input  logic              sw_brk,
    output logic [PSR_W-1:0]  status,
    output logic              emu_narrow,
    output logic              emu_wide,
    output logic [PSR_W-1:0]  push_byte
);
    psr_t st_q, st_d;
    psr_t xchg_st, upd_st;
    logic xchg_act;

    psr_xchg u_xchg (
        .st_i    (st_q),
        .swap_c  (swap_c_req),
        .swap_cv (swap_cv_req),
        .st_o    (xchg_st),
        .active  (xchg_act)
    );

    psr_upd u_upd (
        .st_i      (st_q),
        .flag_we   (flag_we),
        .flag_val  (flag_val),
        .load_we   (load_we),
        .load_data (load_data),
        .st_o      (upd_st)
    );

    psr_push u_push (
        .st_i      (st_q),
        .irq_push  (irq_push),
        .sw_brk    (sw_brk),
        .push_byte (push_byte)
    );

    always_comb begin
        st_d = xchg_act ? xchg_st : upd_st;
        if (st_d.e8) begin
            st_d.p[B_M] = 1'b1;
            st_d.p[B_X] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.p   <= PSR_RESET;
            st_q.e8  <= 1'b1;
            st_q.e16 <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status     = st_q.p;
    assign emu_narrow = st_q.e8;
    assign emu_wide   = st_q.e16;

    assert_width_pinned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        emu_narrow |-> (status[B_M] && status[B_X]));

    assert_swap_c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_c_req && !swap_cv_req) |=>
            (emu_narrow == $past(status[B_C])) && (status[B_C] == $past(emu_narrow)));

    assert_swap_cv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        swap_cv_req |=>
            (emu_narrow == $past(status[B_C])) && (emu_wide == $past(status[B_V]))
            && (status[B_V] == $past(emu_wide)));

    assert_emu_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap_c_req && !swap_cv_req) |=> ($stable(emu_narrow) && $stable(emu_wide)));

    assert_alu_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we[F_C] && !load_we && !swap_c_req && !swap_cv_req) |=>
            (status[B_C] == $past(flag_val[F_C])));

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_we && !swap_c_req && !swap_cv_req) |=>
            (status[7:6] == $past(load_data[7:6])) && (status[3:0] == $past(load_data[3:0])));

    assert_swap_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_c_req || swap_cv_req) |=>
            (status[B_N] == $past(status[B_N])) && (status[B_Z] == $past(status[B_Z])));

    always_comb begin
        if (rst_n && irq_push && emu_narrow)
            assert_brk_bit_R9: assert (push_byte[B_X] == sw_brk && push_byte[B_M]);
    end
endmodule

// File: tb/sim_psr_unit.sv
module sim_psr_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] flag_we, flag_val;
    logic       load_we;
    logic [7:0] load_data;
    logic       swap_c_req, swap_cv_req, irq_push, sw_brk;
    logic [7:0] status, push_byte;
    logic       emu_narrow, emu_wide;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference model state, bit 7..0 = N V M X D I Z C
    bit [7:0] m_p;
    bit       m_e8, m_e16;

    psr_unit u0 (
        .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .flag_val(flag_val),
        .load_we(load_we), .load_data(load_data), .swap_c_req(swap_c_req),
        .swap_cv_req(swap_cv_req), .irq_push(irq_push), .sw_brk(sw_brk),
        .status(status), .emu_narrow(emu_narrow), .emu_wide(emu_wide),
        .push_byte(push_byte)
    );

    always #10 clk = ~clk;

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic check_state(string tag);
        check(tag, "status", status, m_p);
        check(tag, "emu_narrow", {7'd0, emu_narrow}, {7'd0, m_e8});
        check(tag, "emu_wide", {7'd0, emu_wide}, {7'd0, m_e16});
    endtask

    task automatic model_step();
        bit t;
        if (swap_cv_req) begin
            t = m_p[0];  m_p[0] = m_e8;  m_e8 = t;
            t = m_p[6];  m_p[6] = m_e16; m_e16 = t;
        end else if (swap_c_req) begin
            t = m_p[0];  m_p[0] = m_e8;  m_e8 = t;
        end else if (load_we) begin
            m_p = load_data;
        end else begin
            if (flag_we[0]) m_p[0] = flag_val[0];
            if (flag_we[1]) m_p[1] = flag_val[1];
            if (flag_we[2]) m_p[6] = flag_val[2];
            if (flag_we[3]) m_p[7] = flag_val[3];
        end
        if (m_e8) begin
            m_p[5] = 1'b1;
            m_p[4] = 1'b1;
        end
    endtask

    // called at a negedge; applies inputs for one clock cycle
    task automatic cyc(string tag, logic [3:0] we, logic [3:0] val, logic ld,
                       logic [7:0] ldd, logic sc, logic scv, logic irq, logic brk);
        logic [7:0] exp_push;
        flag_we = we; flag_val = val; load_we = ld; load_data = ldd;
        swap_c_req = sc; swap_cv_req = scv; irq_push = irq; sw_brk = brk;
        #2;
        exp_push = m_p;
        if (irq && m_e8) begin
            exp_push[4] = brk;
            exp_push[5] = 1'b1;
        end
        check((irq && m_e8) ? "R9" : "R10", "push_byte", push_byte, exp_push);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_state(tag);
    endtask

    task automatic idle_inputs();
        flag_we = 0; flag_val = 0; load_we = 0; load_data = 0;
        swap_c_req = 0; swap_cv_req = 0; irq_push = 0; sw_brk = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        m_p = 8'h34; m_e8 = 1'b1; m_e16 = 1'b0;
        check_state("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1");

        // R7: load of zeros in emulation keeps width bits at one
        cyc("R7", 4'h0, 4'h0, 1, 8'h00, 0, 0, 0, 0);
        // R9: emulation interrupt push, break on and off
        cyc("R9", 4'h0, 4'h0, 0, 8'h00, 0, 0, 1, 1);
        cyc("R9", 4'h0, 4'h0, 0, 8'h00, 0, 0, 1, 0);
        // R4: leave emulation (carry 0 goes to emu_narrow)
        cyc("R4", 4'h0, 4'h0, 0, 8'h00, 1, 0, 0, 0);
        // R3: native load clears width bits
        cyc("R3", 4'h0, 4'h0, 1, 8'hC3, 0, 0, 0, 0);
        // R10: native interrupt push is plain status
        cyc("R10", 4'h0, 4'h0, 0, 8'h00, 0, 0, 1, 1);
        // R2: mask updates a subset only
        cyc("R2", 4'b0101, 4'b0000, 0, 8'h00, 0, 0, 0, 0);
        cyc("R2", 4'b1010, 4'b1111, 0, 8'h00, 0, 0, 0, 0);
        // R8: load beats flag update
        cyc("R8", 4'hF, 4'h0, 1, 8'h41, 0, 0, 0, 0);
        // R5: both emulation bits swap; both requests high
        cyc("R5", 4'hF, 4'hF, 1, 8'h00, 1, 1, 0, 0);
        // R7: entry into emulation pins widths at the same edge
        cyc("R7", 4'h0, 4'h0, 0, 8'h00, 0, 0, 0, 0);
        // R6: load and flag updates leave emulation bits alone
        cyc("R6", 4'hF, 4'h5, 0, 8'h00, 0, 0, 0, 0);
        cyc("R6", 4'h0, 4'h0, 1, 8'hFF, 0, 0, 0, 0);
        // R8: swap beats load and update
        cyc("R8", 4'hF, 4'h0, 1, 8'h00, 1, 0, 0, 0);
        cyc("R5", 4'h0, 4'h0, 0, 8'h00, 0, 1, 0, 0);

        for (int k = 0; k < 600; k++) begin
            logic [3:0] we, val;
            logic [7:0] ldd;
            logic ld, sc, scv, irq, brk;
            string tag;
            we  = 4'($urandom);
            val = 4'($urandom);
            ldd = 8'($urandom);
            ld  = ($urandom % 4) == 0;
            sc  = ($urandom % 6) == 0;
            scv = ($urandom % 6) == 0;
            irq = ($urandom % 3) == 0;
            brk = 1'($urandom);
            if (scv)      tag = (ld || we != 0) ? "R8" : "R5";
            else if (sc)  tag = (ld || we != 0) ? "R8" : "R4";
            else if (ld)  tag = "R3";
            else if (we != 0) tag = "R2";
            else          tag = "R6";
            cyc(tag, we, val, ld, ldd, sc, scv, irq, brk);
        end

        idle_inputs();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule